// File: doc/BRIEF.md
# Policy-Controlled 8-bit Arithmetic/Logic Unit

This block performs one arithmetic or logic operation per execute strobe on an accumulator value and an operand. It stores the result and a four-bit status nibble (zero, subtract, half-carry, carry) in registers. The nibble is presented as the upper half of a status byte whose lower half always reads zero.

Each of the four status flags has its own 2-bit policy input. The policy either forces the flag to 0, forces it to 1, takes the value the operation computes, or keeps the stored value. The surrounding sequencer can therefore give every instruction its own flag rule without the ALU having a fixed rule per opcode.

Add-with-carry draws its carry-in from the stored carry flag. Compare produces subtract flags but writes the unchanged accumulator into the result register.

Top module: `alu8_flagged`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both `res_o` and `flags_o` are cleared to 0.
- R2: `flags_o` bit 7 is zero, bit 6 is subtract, bit 5 is half-carry and bit 4 is carry. Bits 3..0 are always 0.
- R3: The policy code for each flag acts independently of the other flags: 0 clears the flag, 1 sets it, 2 takes the computed value and 3 keeps the stored value.
- R4: Add (op 1) stores (acc+opd) mod 256. Computed flags: zero when that value is 0, subtract 0, half-carry when acc[3:0]+opd[3:0] > 15, carry when acc+opd > 255.
- R5: Add-with-carry (op 7) behaves as add, with the stored carry flag added into both the 9-bit sum and the low-nibble sum.
- R6: Subtract (op 2) stores (acc-opd) mod 256. Computed flags: zero when that value is 0, subtract 1, half-carry when acc[3:0] < opd[3:0], carry when opd > acc.
- R7: Compare (op 3) computes the same four flags as subtract, and `res_o` becomes the accumulator input.
- R8: AND (op 4), OR (op 5) and XOR (op 6) store the bitwise result. Computed zero follows that result and subtract is 0. Half-carry is 1 for AND and 0 for OR and XOR. Carry is 0 for all three.
- R9: Increment (op 8) and decrement (op 9) ignore the operand and store acc+1 or acc-1 mod 256. Computed half-carry is a low-nibble carry (acc[3:0]=15) or borrow (acc[3:0]=0). Computed subtract is 0 for increment and 1 for decrement. Under the compute policy, carry keeps its stored value.
- R10: When `exe_i` is low at a clock edge, `res_o` and `flags_o` do not change.
- R11: Op codes 0 and 10..15 are reserved. An execute strobe with such a code changes neither `res_o` nor `flags_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| exe_i | input | 1 | Execute strobe; registers update at the edge when high |
| op_i | input | 4 | Operation code (1..9 defined) |
| acc_i | input | 8 | Accumulator operand |
| opd_i | input | 8 | Second operand |
| zpol_i | input | 2 | Policy for the zero flag |
| npol_i | input | 2 | Policy for the subtract flag |
| hpol_i | input | 2 | Policy for the half-carry flag |
| cpol_i | input | 2 | Policy for the carry flag |
| res_o | output | 8 | Registered result |
| flags_o | output | 8 | Status byte; flags in bits 7..4 |

## Verification
Both outputs come from a single register stage. The effect of a strobe is therefore visible one clock edge after the inputs are applied, and a non-executing or reserved cycle must show the values from before that edge. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares results and flags a quarter period after that rising edge, so every comparison falls in the first cycle where the new values are due. Because add-with-carry and the keep policy depend on the stored carry, the model carries its own flag state forward through every step, including skipped ones.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes, flag policy codes and flag positions
// for the policy-controlled ALU. Assumes a 4-bit op field and 2-bit policies.
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_CMP  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_ADC  = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        POL_CLR  = 2'd0,
        POL_SET  = 2'd1,
        POL_CALC = 2'd2,
        POL_KEEP = 2'd3
    } flag_pol_e;

    // Positions inside the 4-bit flag nibble (nibble bit 3 maps to byte bit 7)
    localparam int FLAG_COUNT = 4;
    localparam int FLG_Z = 3;
    localparam int FLG_N = 2;
    localparam int FLG_H = 1;
    localparam int FLG_C = 0;

    // Returns 1 for every defined operation code
    function automatic logic op_defined(input logic [3:0] op);
        return (op >= OP_ADD) && (op <= OP_DEC);
    endfunction

endpackage

// File: rtl/alu8_split_adder.sv
// Module: adder/subtractor split at the half-width boundary. It returns the
// sum, the low-half carry (or borrow when sub_i=1) and the full carry (or
// borrow). Assumes DATA_W is even. Subtraction ignores cin_i.
module alu8_split_adder #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              half_o,
    output logic              full_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int UP_W   = DATA_W - HALF_W;

    logic [DATA_W-1:0] b_eff;
    logic              c_in;
    logic [HALF_W:0]   lo_sum;
    logic [UP_W:0]     hi_sum;

    // Operand conditioning: two's complement for subtraction
    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        c_in  = sub_i ? 1'b1 : cin_i;
    end

    // Low half then high half, so the carry between halves is visible
    always_comb begin
        lo_sum = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, c_in};
        hi_sum = {1'b0, a_i[DATA_W-1:HALF_W]} + {1'b0, b_eff[DATA_W-1:HALF_W]}
               + {{UP_W{1'b0}}, lo_sum[HALF_W]};
    end

    // Output packing: a borrow is the inverted carry when subtracting
    always_comb begin
        sum_o  = {hi_sum[UP_W-1:0], lo_sum[HALF_W-1:0]};
        half_o = lo_sum[HALF_W] ^ sub_i;
        full_o = hi_sum[UP_W] ^ sub_i;
    end
endmodule

// File: rtl/alu8_datapath.sv
// Module: operation decode and result selection. It produces the value to
// store, the computed flag nibble, and a hold mask for flags that the
// operation leaves alone under the compute policy. Purely combinational.
module alu8_datapath
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]            op_i,
    input  logic [DATA_W-1:0]     acc_i,
    input  logic [DATA_W-1:0]     opd_i,
    input  logic                  cin_i,
    output logic [DATA_W-1:0]     wr_o,
    output logic [FLAG_COUNT-1:0] calc_o,
    output logic [FLAG_COUNT-1:0] hold_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic              is_sub;
    logic              is_step;
    logic [DATA_W-1:0] add_b;
    logic              add_cin;
    logic [DATA_W-1:0] sum;
    logic              half_c;
    logic              full_c;
    logic [DATA_W-1:0] logic_val;
    logic [DATA_W-1:0] zero_src;

    // Adder control: which operand, which direction, which carry-in
    always_comb begin
        is_step = (op_i == OP_INC) || (op_i == OP_DEC);
        is_sub  = (op_i == OP_SUB) || (op_i == OP_CMP) || (op_i == OP_DEC);
        add_b   = is_step ? ONE : opd_i;
        add_cin = (op_i == OP_ADC) ? cin_i : 1'b0;
    end

    alu8_split_adder #(.DATA_W(DATA_W)) u_adder (
        .a_i   (acc_i),
        .b_i   (add_b),
        .cin_i (add_cin),
        .sub_i (is_sub),
        .sum_o (sum),
        .half_o(half_c),
        .full_o(full_c)
    );

    // Bitwise unit
    always_comb begin
        unique case (op_i)
            OP_AND:  logic_val = acc_i & opd_i;
            OP_OR:   logic_val = acc_i | opd_i;
            default: logic_val = acc_i ^ opd_i;
        endcase
    end

    // Result and computed flags per operation
    always_comb begin
        wr_o     = acc_i;
        zero_src = sum;
        calc_o   = '0;
        hold_o   = '0;
        case (op_i)
            OP_ADD, OP_ADC: begin
                wr_o          = sum;
                calc_o[FLG_H] = half_c;
                calc_o[FLG_C] = full_c;
            end
            OP_SUB: begin
                wr_o          = sum;
                calc_o[FLG_N] = 1'b1;
                calc_o[FLG_H] = half_c;
                calc_o[FLG_C] = full_c;
            end
            OP_CMP: begin
                wr_o          = acc_i;
                calc_o[FLG_N] = 1'b1;
                calc_o[FLG_H] = half_c;
                calc_o[FLG_C] = full_c;
            end
            OP_AND: begin
                wr_o          = logic_val;
                zero_src      = logic_val;
                calc_o[FLG_H] = 1'b1;
            end
            OP_OR, OP_XOR: begin
                wr_o     = logic_val;
                zero_src = logic_val;
            end
            OP_INC, OP_DEC: begin
                wr_o          = sum;
                calc_o[FLG_N] = (op_i == OP_DEC);
                calc_o[FLG_H] = half_c;
                hold_o[FLG_C] = 1'b1;
            end
            default: begin
                wr_o = acc_i;
            end
        endcase
        calc_o[FLG_Z] = (zero_src == '0);
    end
endmodule

// File: rtl/alu8_flag_policy.sv
// Module: applies one 2-bit policy per flag to choose the next flag value.
// A flag whose hold bit is set keeps its stored value under the compute
// policy. Combinational; one selector per flag is generated.
module alu8_flag_policy
    import alu8_pkg::*;
#(
    parameter int NFLAGS = 4
) (
    input  logic [2*NFLAGS-1:0] pol_i,
    input  logic [NFLAGS-1:0]   calc_i,
    input  logic [NFLAGS-1:0]   hold_i,
    input  logic [NFLAGS-1:0]   cur_i,
    output logic [NFLAGS-1:0]   nxt_o
);
    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        // Per-flag selector
        always_comb begin
            unique case (pol_i[2*g +: 2])
                POL_CLR:  nxt_o[g] = 1'b0;
                POL_SET:  nxt_o[g] = 1'b1;
                POL_CALC: nxt_o[g] = hold_i[g] ? cur_i[g] : calc_i[g];
                default:  nxt_o[g] = cur_i[g];
            endcase
        end
    end
endmodule

// File: rtl/alu8_flagged.sv
// Module: top of the policy-controlled ALU. It registers the result and the
// flag nibble on an execute strobe with a defined op code. The flags appear
// in the upper half of the status byte. Synchronous active-low reset.
module alu8_flagged
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exe_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opd_i,
    input  logic [1:0]        zpol_i,
    input  logic [1:0]        npol_i,
    input  logic [1:0]        hpol_i,
    input  logic [1:0]        cpol_i,
    output logic [DATA_W-1:0] res_o,
    output logic [7:0]        flags_o
);
    logic [DATA_W-1:0]     res_q;
    logic [FLAG_COUNT-1:0] flg_q;
    logic [DATA_W-1:0]     wr_val;
    logic [FLAG_COUNT-1:0] calc_flg;
    logic [FLAG_COUNT-1:0] hold_flg;
    logic [FLAG_COUNT-1:0] nxt_flg;
    logic                  commit;

    alu8_datapath #(.DATA_W(DATA_W)) u_dp (
        .op_i  (op_i),
        .acc_i (acc_i),
        .opd_i (opd_i),
        .cin_i (flg_q[FLG_C]),
        .wr_o  (wr_val),
        .calc_o(calc_flg),
        .hold_o(hold_flg)
    );

    alu8_flag_policy #(.NFLAGS(FLAG_COUNT)) u_pol (
        .pol_i ({zpol_i, npol_i, hpol_i, cpol_i}),
        .calc_i(calc_flg),
        .hold_i(hold_flg),
        .cur_i (flg_q),
        .nxt_o (nxt_flg)
    );

    // Commit only for strobed, defined operations
    always_comb commit = exe_i && op_defined(op_i);

    // Result and flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
        end else if (commit) begin
            res_q <= wr_val;
            flg_q <= nxt_flg;
        end
    end

    // Output mapping: flag nibble over a zero low nibble
    always_comb begin
        res_o   = res_q;
        flags_o = {flg_q, 4'b0000};
    end
endmodule

// File: rtl/alu8_flagged_chk.sv
// Module: property checker for alu8_flagged, attached with bind.
module alu8_flagged_chk
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exe_i,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [1:0]        zpol_i,
    input logic [1:0]        hpol_i,
    input logic [1:0]        cpol_i,
    input logic [DATA_W-1:0] res_o,
    input logic [7:0]        flags_o
);
    logic live;
    logic spare;

    // Strobe qualifiers seen by the checker
    always_comb begin
        live  = exe_i && (op_i >= 4'd1) && (op_i <= 4'd9);
        spare = exe_i && ((op_i == 4'd0) || (op_i > 4'd9));
    end

    // R2
    low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[3:0] == 4'h0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exe_i |=> ($stable(res_o) && $stable(flags_o)));

    // R11
    reserved_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spare |=> ($stable(res_o) && $stable(flags_o)));

    // R3
    zero_forced_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && zpol_i == 2'd1) |=> flags_o[7]);

    // R3
    carry_forced_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cpol_i == 2'd0) |=> !flags_o[4]);

    // R3
    carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cpol_i == 2'd3) |=> $stable(flags_o[4]));

    // R7
    compare_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_i && op_i == 4'd3) |=> (res_o == $past(acc_i)));

    // R8
    and_half_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_i && op_i == 4'd4 && hpol_i == 2'd2) |=> flags_o[5]);
endmodule

bind alu8_flagged alu8_flagged_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .exe_i  (exe_i),
    .op_i   (op_i),
    .acc_i  (acc_i),
    .zpol_i (zpol_i),
    .hpol_i (hpol_i),
    .cpol_i (cpol_i),
    .res_o  (res_o),
    .flags_o(flags_o)
);

// File: tb/alu8_flagged_bench.sv
module alu8_flagged_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exe_i = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] acc_i = 8'd0;
    logic [7:0] opd_i = 8'd0;
    logic [1:0] zpol_i = 2'd2, npol_i = 2'd2, hpol_i = 2'd2, cpol_i = 2'd2;
    logic [7:0] res_o;
    logic [7:0] flags_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    int m_res = 0;
    int m_z = 0, m_n = 0, m_h = 0, m_c = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_flagged u_alu8_flagged (
        .clk(clk), .rst_n(rst_n), .exe_i(exe_i), .op_i(op_i),
        .acc_i(acc_i), .opd_i(opd_i), .zpol_i(zpol_i), .npol_i(npol_i),
        .hpol_i(hpol_i), .cpol_i(cpol_i), .res_o(res_o), .flags_o(flags_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int pick(input int pol, input int calc, input int old);
        case (pol)
            0: return 0;
            1: return 1;
            2: return calc;
            default: return old;
        endcase
    endfunction

    // Behavioural model of one clock edge
    task automatic model_step();
        int a = acc_i, b = opd_i, o = op_i;
        int r = m_res, cz = 0, cn = 0, ch = 0, cc = 0, s;
        if (!exe_i || o < 1 || o > 9) return;
        case (o)
            1, 7: begin
                s = a + b + ((o == 7) ? m_c : 0);
                r = s % 256;
                ch = (((a % 16) + (b % 16) + ((o == 7) ? m_c : 0)) > 15);
                cc = (s > 255);
                cz = (r == 0);
            end
            2, 3: begin
                s = (a - b + 256) % 256;
                r = (o == 3) ? a : s;
                cz = (s == 0); cn = 1;
                ch = ((a % 16) < (b % 16)); cc = (b > a);
            end
            4: begin r = a & b; cz = (r == 0); ch = 1; end
            5: begin r = a | b; cz = (r == 0); end
            6: begin r = a ^ b; cz = (r == 0); end
            8: begin r = (a + 1) % 256; cz = (r == 0); ch = ((a % 16) == 15); cc = m_c; end
            default: begin r = (a + 255) % 256; cz = (r == 0); cn = 1; ch = ((a % 16) == 0); cc = m_c; end
        endcase
        m_res = r;
        m_z = pick(zpol_i, cz, m_z);
        m_n = pick(npol_i, cn, m_n);
        m_h = pick(hpol_i, ch, m_h);
        m_c = pick(cpol_i, cc, m_c);
    endtask

    function automatic string op_tag(input int o);
        case (o)
            1: return "R4";  2: return "R6";  3: return "R7";
            4, 5, 6: return "R8";  7: return "R5";  8, 9: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic compare(input string tag);
        int ef = m_z * 128 + m_n * 64 + m_h * 32 + m_c * 16;
        check(res_o == m_res[7:0], tag, "result", res_o, m_res);
        check(flags_o == ef[7:0], tag, "flags", flags_o, ef);
        check(flags_o[3:0] == 4'h0, "R2", "low nibble", flags_o[3:0], 0);
    endtask

    task automatic run(input int o, input int a, input int b, input int pz,
                       input int pn, input int ph, input int pc, input bit ex,
                       input string tag);
        @(negedge clk);
        op_i = o[3:0]; acc_i = a[7:0]; opd_i = b[7:0];
        zpol_i = pz[1:0]; npol_i = pn[1:0]; hpol_i = ph[1:0]; cpol_i = pc[1:0];
        exe_i = ex;
        @(posedge clk);
        model_step();
        #(CLK_PERIOD/4);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        check(res_o == 8'h00, "R1", "reset result", res_o, 0);
        check(flags_o == 8'h00, "R1", "reset flags", flags_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 add corners
        run(1, 8'h0F, 8'h01, 2, 2, 2, 2, 1, "R4");
        run(1, 8'hFF, 8'h01, 2, 2, 2, 2, 1, "R4");
        // R5 add-with-carry using the stored carry
        run(7, 8'h10, 8'h20, 2, 2, 2, 2, 1, "R5");
        run(7, 8'h0F, 8'hF0, 2, 2, 2, 1, 1, "R5");
        run(7, 8'h0F, 8'hF0, 2, 2, 2, 2, 1, "R5");
        // R6 subtract
        run(2, 8'h10, 8'h01, 2, 2, 2, 2, 1, "R6");
        run(2, 8'h01, 8'h02, 2, 2, 2, 2, 1, "R6");
        // R7 compare
        run(3, 8'h42, 8'h42, 2, 2, 2, 2, 1, "R7");
        run(3, 8'h05, 8'h80, 2, 2, 2, 2, 1, "R7");
        // R8 bitwise
        run(4, 8'hF0, 8'h0F, 2, 2, 2, 2, 1, "R8");
        run(5, 8'h00, 8'h00, 2, 2, 2, 2, 1, "R8");
        run(6, 8'h5A, 8'hA5, 2, 2, 2, 2, 1, "R8");
        // R9 increment and decrement, carry kept
        run(1, 8'hFF, 8'h02, 2, 2, 2, 2, 1, "R9");
        run(8, 8'hFF, 8'h33, 2, 2, 2, 2, 1, "R9");
        run(9, 8'h10, 8'h77, 2, 2, 2, 2, 1, "R9");
        run(9, 8'h01, 8'h00, 2, 2, 2, 2, 1, "R9");
        // R3 policies
        run(1, 8'h01, 8'h01, 1, 1, 1, 1, 1, "R3");
        run(2, 8'h00, 8'h01, 3, 3, 3, 3, 1, "R3");
        run(1, 8'hFF, 8'hFF, 0, 0, 0, 0, 1, "R3");
        run(4, 8'h00, 8'h00, 3, 1, 0, 1, 1, "R3");
        // R10 idle cycles
        run(1, 8'h12, 8'h34, 1, 1, 1, 1, 0, "R10");
        run(2, 8'h00, 8'hFF, 2, 2, 2, 2, 0, "R10");
        // R11 reserved codes
        run(0, 8'h77, 8'h01, 0, 0, 0, 0, 1, "R11");
        run(12, 8'h77, 8'h01, 1, 1, 1, 1, 1, "R11");
        run(15, 8'h00, 8'h00, 2, 2, 2, 2, 1, "R11");

        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            int o = $urandom_range(0, 15);
            int ex = ($urandom_range(0, 7) != 0);
            run(o, $urandom_range(0, 255), $urandom_range(0, 255),
                $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3), ex[0],
                ex ? op_tag(o) : "R10");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule